// File: doc/BRIEF.md
# Context Save/Restore Program Sequencer

This block runs a short microprogram that moves engine state between the engine's registers and a context memory. The host first uploads up to 256 instruction words of 24 bits: it clears the upload index, then writes each word to a data port. The index steps forward by one after each word. A start pulse then runs the program from address 0. The instructions test, wait on or write single bits of a 128-entry flag space. Some flags are set by host request pulses, some follow sampled status inputs, one always reads as 1, and the rest belong to the program.

Transfer instructions raise a request carrying a register address, a word count, the current context position and a direction bit. The sequencer holds the request until a done handshake. It then advances the context position by the count. Flag 0 chooses the direction (1 = save, 0 = load), so one program body can serve both operations. Three command words produce one-cycle notification pulses, and one command word ends the run.

Top module: `ctxseq_top`

The controller has four states: IDLE, RUN, STALL and XFER. The transitions are:
- IDLE to RUN on start.
- RUN to IDLE on the end command, or when the program counter reaches the loaded length.
- RUN to STALL when a wait condition is false.
- STALL to RUN when the condition holds.
- RUN to XFER on a transfer instruction.
- XFER to RUN on done.

## Requirements
- R1: Asserting `up_index_clr` sets the upload index to 0. Each `up_data_we` stores `up_data` at the index, and the index then increments. Writes made once 256 words are stored are ignored. The number of stored words is the program length.
- R2: After reset, `busy` and `xfer_req` are low. A `start` pulse in idle raises `busy` on the next clock edge, clears the context position to 0, and starts execution at address 0.
- R3: Word 0x60000E ends the run, and `busy` falls on the clock edge that executes it. Reaching a program counter equal to the program length also ends the run, one edge later.
- R4: A word with bits 23:20 = 1 is a register transfer. Its count is bits 19:14 and its address is bits 13:0. On the next edge `xfer_req` rises with `xfer_bulk` = 0, `xfer_dir` = flag 0, and `xfer_pos` = the context position. The request and all of its fields hold steady until `xfer_done`.
- R5: On the edge where `xfer_done` is high during a request, `xfer_req` falls and the context position grows by `xfer_cnt`. The next transfer carries the new position.
- R6: Bits 23:20 = 2 load bits 19:0 into a length register. Bits 23:20 = 8 issue a bulk transfer with `xfer_bulk` = 1, count = the length register and address = bits 13:0.
- R7: Bits 23:20 = 4 form a branch. The target is bits 15:8 and the flag index is bits 6:0. With bit 7 = 0 the branch is taken when the flag is 1; with bit 7 = 1 it is taken when the flag is 0. Otherwise execution continues at the next word.
- R8: Bits 23:20 = 5 stall until flag bits 6:0 equals bit 7. The flag is re-checked every cycle, and `busy` stays high during the stall.
- R9: Bits 23:20 = 7 write bit 7 into flag bits 6:0. Writes to flags 96, 100, 101 and 104 have no effect.
- R10: Flag map: 0 is direction, 5 is the user-save request (set by `host_usave_set`) and 6 is the user-load request (set by `host_uload_set`). 96, 100 and 101 are `stat_busy`, `stat_asave` and `stat_aload` through one sampling register. 104 always reads 1. All other flags are program-owned and reset to 0.
- R11: If a host request pulse and a program write to the same flag fall on the same edge, the host's set wins.
- R12: Words 0x600007, 0x600009 and 0x60000A each raise `pulse_to_swap`, `pulse_to_cur` or `pulse_ctx_ptr` respectively for exactly one cycle. At most one of the three pulses is high at a time.
- R13: Any other word only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_index_clr | input | 1 | Clear the upload index |
| up_data_we | input | 1 | Store one program word |
| up_data | input | 24 | Program word |
| start | input | 1 | Begin execution at address 0 |
| host_usave_set | input | 1 | Set the user-save flag |
| host_uload_set | input | 1 | Set the user-load flag |
| stat_busy | input | 1 | Engine busy status |
| stat_asave | input | 1 | Automatic save pending |
| stat_aload | input | 1 | Automatic load pending |
| busy | output | 1 | Program running |
| xfer_req | output | 1 | Transfer request |
| xfer_bulk | output | 1 | Request is a bulk transfer |
| xfer_dir | output | 1 | 1 = save, 0 = load |
| xfer_addr | output | 14 | Register word address |
| xfer_cnt | output | 20 | Word count |
| xfer_pos | output | 20 | Context memory position |
| xfer_done | input | 1 | Transfer complete |
| pulse_to_swap | output | 1 | Next-to-swap notification |
| pulse_to_cur | output | 1 | Next-to-current notification |
| pulse_ctx_ptr | output | 1 | Set-context-pointer notification |

## Verification
A host request pulse on the user-save flag can land on the same edge as a program instruction that clears that flag. The bench provokes this by raising `host_usave_set` in the cycle right after `start`, which is the cycle in which the clearing instruction at address 0 executes. A branch on the same flag follows, and the notification pulse the branch reaches shows which write survived. A control run without the host pulse must take the other path.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;

    localparam int unsigned INSN_W = 24;
    localparam int unsigned LEN_W  = 20;

    // flag indices whose position the sequencer behaviour depends on
    localparam int unsigned FLAG_DIR    = 0;
    localparam int unsigned FLAG_USAVE  = 5;
    localparam int unsigned FLAG_ULOAD  = 6;
    localparam int unsigned FLAG_STBUSY = 96;
    localparam int unsigned FLAG_ASAVE  = 100;
    localparam int unsigned FLAG_ALOAD  = 101;
    localparam int unsigned FLAG_ONE    = 104;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_REGX,
        OP_LEN,
        OP_BRANCH,
        OP_WAIT,
        OP_SETF,
        OP_TOSWAP,
        OP_TOCUR,
        OP_CTXPTR,
        OP_END,
        OP_BULK
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_STALL,
        S_XFER
    } seq_state_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  target;
        logic        polarity;
        logic [6:0]  flag_idx;
        logic [5:0]  reg_cnt;
        logic [13:0] reg_addr;
        logic [19:0] imm;
    } insn_t;

endpackage

// File: rtl/ctxseq_store.sv
module ctxseq_store #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned W     = 24,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_clr_i,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o,
    output logic [AW:0]   prog_len_o
);

    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_idx_q;
    logic         accept;

    assign accept = wr_en_i && !idx_clr_i && (wr_idx_q < DEPTH_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx_q <= '0;
        end else if (idx_clr_i) begin
            wr_idx_q <= '0;
        end else if (accept) begin
            wr_idx_q <= wr_idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_idx_q[AW-1:0]] <= wr_data_i;
        end
    end

    assign rd_data_o  = mem[rd_addr_i];
    assign prog_len_o = wr_idx_q;

    // R1: the upload index never passes the store depth
    p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_idx_q <= DEPTH_C);

    // R1: a full store ignores further words
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx_q == DEPTH_C && !idx_clr_i) |=> wr_idx_q == DEPTH_C);

endmodule

// File: rtl/ctxseq_decode.sv
module ctxseq_decode
    import ctxseq_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output insn_t             insn_o
);

    always_comb begin
        insn_o.target   = word_i[15:8];
        insn_o.polarity = word_i[7];
        insn_o.flag_idx = word_i[6:0];
        insn_o.reg_cnt  = word_i[19:14];
        insn_o.reg_addr = word_i[13:0];
        insn_o.imm      = word_i[19:0];
        unique case (word_i[23:20])
            4'h1:    insn_o.op = OP_REGX;
            4'h2:    insn_o.op = OP_LEN;
            4'h4:    insn_o.op = OP_BRANCH;
            4'h5:    insn_o.op = OP_WAIT;
            4'h7:    insn_o.op = OP_SETF;
            4'h8:    insn_o.op = OP_BULK;
            4'h6: begin
                unique case (word_i[19:0])
                    20'h00007: insn_o.op = OP_TOSWAP;
                    20'h00009: insn_o.op = OP_TOCUR;
                    20'h0000A: insn_o.op = OP_CTXPTR;
                    20'h0000E: insn_o.op = OP_END;
                    default:   insn_o.op = OP_NOP;
                endcase
            end
            default: insn_o.op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/ctxseq_flags.sv
module ctxseq_flags
    import ctxseq_pkg::*;
#(
    parameter int unsigned NFLAG = 128,
    localparam int unsigned IW   = $clog2(NFLAG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_busy_i,
    input  logic          stat_asave_i,
    input  logic          stat_aload_i,
    input  logic          host_usave_i,
    input  logic          host_uload_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] idx_i,
    input  logic          wr_val_i,
    output logic          rd_val_o,
    output logic          dir_o
);

    logic [NFLAG-1:0] bank_q;
    logic             st_busy_q;
    logic             st_asave_q;
    logic             st_aload_q;
    logic             read_only;

    always_comb begin
        unique case (32'(idx_i))
            FLAG_STBUSY, FLAG_ASAVE, FLAG_ALOAD, FLAG_ONE: read_only = 1'b1;
            default:                                       read_only = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q     <= '0;
            st_busy_q  <= 1'b0;
            st_asave_q <= 1'b0;
            st_aload_q <= 1'b0;
        end else begin
            st_busy_q  <= stat_busy_i;
            st_asave_q <= stat_asave_i;
            st_aload_q <= stat_aload_i;
            if (wr_en_i && !read_only) begin
                bank_q[idx_i] <= wr_val_i;
            end
            // host requests come last so they win over a program write
            if (host_usave_i) begin
                bank_q[FLAG_USAVE] <= 1'b1;
            end
            if (host_uload_i) begin
                bank_q[FLAG_ULOAD] <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (32'(idx_i))
            FLAG_STBUSY: rd_val_o = st_busy_q;
            FLAG_ASAVE:  rd_val_o = st_asave_q;
            FLAG_ALOAD:  rd_val_o = st_aload_q;
            FLAG_ONE:    rd_val_o = 1'b1;
            default:     rd_val_o = bank_q[idx_i];
        endcase
    end

    assign dir_o = bank_q[FLAG_DIR];

    // R11: a host save request always lands, whatever the program writes
    p_host_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_usave_i |=> bank_q[FLAG_USAVE]);

    p_host_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_uload_i |=> bank_q[FLAG_ULOAD]);

    // R10: status flags follow their inputs through one register
    p_status_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_busy_q == $past(stat_busy_i)) && (st_asave_q == $past(stat_asave_i)));

endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
    import ctxseq_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned NFLAG = 128,
    parameter int unsigned POS_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_index_clr,
    input  logic              up_data_we,
    input  logic [23:0]       up_data,
    input  logic              start,
    input  logic              host_usave_set,
    input  logic              host_uload_set,
    input  logic              stat_busy,
    input  logic              stat_asave,
    input  logic              stat_aload,
    output logic              busy,
    output logic              xfer_req,
    output logic              xfer_bulk,
    output logic              xfer_dir,
    output logic [13:0]       xfer_addr,
    output logic [19:0]       xfer_cnt,
    output logic [POS_W-1:0]  xfer_pos,
    input  logic              xfer_done,
    output logic              pulse_to_swap,
    output logic              pulse_to_cur,
    output logic              pulse_ctx_ptr
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned IW = $clog2(NFLAG);

    seq_state_e        state_q;
    logic [AW:0]       pc_q;
    logic [LEN_W-1:0]  len_q;
    logic [POS_W-1:0]  pos_q;

    logic [INSN_W-1:0] word;
    logic [AW:0]       prog_len;
    insn_t             insn;
    logic              past_end;
    logic              flag_val;
    logic              flag_dir;
    logic              take_br;
    logic              wait_ok;
    logic              set_we;
    logic [AW:0]       pc_next;

    ctxseq_store #(.DEPTH(DEPTH), .W(INSN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_clr_i  (up_index_clr),
        .wr_en_i    (up_data_we),
        .wr_data_i  (up_data),
        .rd_addr_i  (pc_q[AW-1:0]),
        .rd_data_o  (word),
        .prog_len_o (prog_len)
    );

    ctxseq_decode u_dec (
        .word_i (word),
        .insn_o (insn)
    );

    ctxseq_flags #(.NFLAG(NFLAG)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_busy_i  (stat_busy),
        .stat_asave_i (stat_asave),
        .stat_aload_i (stat_aload),
        .host_usave_i (host_usave_set),
        .host_uload_i (host_uload_set),
        .wr_en_i      (set_we),
        .idx_i        (IW'(insn.flag_idx)),
        .wr_val_i     (insn.polarity),
        .rd_val_o     (flag_val),
        .dir_o        (flag_dir)
    );

    assign past_end = (pc_q >= prog_len);
    assign take_br  = (flag_val != insn.polarity);
    assign wait_ok  = (flag_val == insn.polarity);
    assign set_we   = (state_q == S_RUN) && !past_end && (insn.op == OP_SETF);
    assign pc_next  = pc_q + 1'b1;

    // state, program counter, length and position registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            len_q   <= '0;
            pos_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_q <= S_RUN;
                        pc_q    <= '0;
                        pos_q   <= '0;
                    end
                end
                S_RUN: begin
                    if (past_end) begin
                        state_q <= S_IDLE;
                    end else begin
                        unique case (insn.op)
                            OP_END:           state_q <= S_IDLE;
                            OP_REGX, OP_BULK: state_q <= S_XFER;
                            OP_LEN: begin
                                len_q <= insn.imm;
                                pc_q  <= pc_next;
                            end
                            OP_BRANCH: begin
                                pc_q <= take_br ? (AW+1)'(insn.target) : pc_next;
                            end
                            OP_WAIT: begin
                                if (wait_ok) begin
                                    pc_q <= pc_next;
                                end else begin
                                    state_q <= S_STALL;
                                end
                            end
                            default: pc_q <= pc_next;
                        endcase
                    end
                end
                S_STALL: begin
                    if (wait_ok) begin
                        pc_q    <= pc_next;
                        state_q <= S_RUN;
                    end
                end
                S_XFER: begin
                    if (xfer_done) begin
                        pos_q   <= pos_q + POS_W'(xfer_cnt);
                        pc_q    <= pc_next;
                        state_q <= S_RUN;
                    end
                end
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            xfer_req      <= 1'b0;
            xfer_bulk     <= 1'b0;
            xfer_dir      <= 1'b0;
            xfer_addr     <= '0;
            xfer_cnt      <= '0;
            xfer_pos      <= '0;
            pulse_to_swap <= 1'b0;
            pulse_to_cur  <= 1'b0;
            pulse_ctx_ptr <= 1'b0;
        end else begin
            pulse_to_swap <= 1'b0;
            pulse_to_cur  <= 1'b0;
            pulse_ctx_ptr <= 1'b0;
            unique case (state_q)
                S_IDLE: busy <= start;
                S_RUN: begin
                    if (past_end || insn.op == OP_END) begin
                        busy <= 1'b0;
                    end else begin
                        unique case (insn.op)
                            OP_REGX, OP_BULK: begin
                                xfer_req  <= 1'b1;
                                xfer_bulk <= (insn.op == OP_BULK);
                                xfer_dir  <= flag_dir;
                                xfer_addr <= insn.reg_addr;
                                xfer_cnt  <= (insn.op == OP_BULK) ? len_q : LEN_W'(insn.reg_cnt);
                                xfer_pos  <= pos_q;
                            end
                            OP_TOSWAP: pulse_to_swap <= 1'b1;
                            OP_TOCUR:  pulse_to_cur  <= 1'b1;
                            OP_CTXPTR: pulse_ctx_ptr <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                S_STALL: ;
                S_XFER: begin
                    if (xfer_done) begin
                        xfer_req <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R4: a pending request keeps all of its fields
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> xfer_req && $stable(xfer_addr) && $stable(xfer_cnt)
                                     && $stable(xfer_pos) && $stable(xfer_dir) && $stable(xfer_bulk));

    // R5: completion drops the request and moves the position by the count
    p_pos_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_done) |=> !xfer_req && (pos_q == $past(pos_q) + POS_W'($past(xfer_cnt))));

    // R12: notification pulses never overlap and last one cycle
    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pulse_to_swap, pulse_to_cur, pulse_ctx_ptr}));

    p_pulse_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_to_cur |=> !pulse_to_cur);

    // R3: no request is outstanding outside a run
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_req);

    // R2: start from idle raises busy on the next edge
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> busy);

    // R8: a stalled wait keeps the program counter
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STALL && !wait_ok) |=> $stable(pc_q) && busy);

endmodule

// File: tb/sim_ctxseq_top.sv
`timescale 1ns/1ps
module sim_ctxseq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_index_clr, up_data_we, start;
    logic [23:0] up_data;
    logic        host_usave_set, host_uload_set;
    logic        stat_busy, stat_asave, stat_aload;
    logic        busy, xfer_req, xfer_bulk, xfer_dir, xfer_done;
    logic [13:0] xfer_addr;
    logic [19:0] xfer_cnt, xfer_pos;
    logic        pulse_to_swap, pulse_to_cur, pulse_ctx_ptr;

    always #2 clk = ~clk;

    ctxseq_top u0 (
        .clk(clk), .rst_n(rst_n), .up_index_clr(up_index_clr), .up_data_we(up_data_we),
        .up_data(up_data), .start(start), .host_usave_set(host_usave_set),
        .host_uload_set(host_uload_set), .stat_busy(stat_busy), .stat_asave(stat_asave),
        .stat_aload(stat_aload), .busy(busy), .xfer_req(xfer_req), .xfer_bulk(xfer_bulk),
        .xfer_dir(xfer_dir), .xfer_addr(xfer_addr), .xfer_cnt(xfer_cnt), .xfer_pos(xfer_pos),
        .xfer_done(xfer_done), .pulse_to_swap(pulse_to_swap), .pulse_to_cur(pulse_to_cur),
        .pulse_ctx_ptr(pulse_ctx_ptr)
    );

    int n_chk = 0;
    int n_bad = 0;
    int c_swap = 0, c_cur = 0, c_ptr = 0, c_req = 0;
    int b_swap, b_cur, b_ptr, b_req;

    always @(posedge clk) begin
        if (pulse_to_swap) c_swap++;
        if (pulse_to_cur)  c_cur++;
        if (pulse_ctx_ptr) c_ptr++;
        if (xfer_req)      c_req++;
    end

    // {pre word, branch word, host save pulse, {busy,asave,aload}, taken}
    localparam int NROW = 13;
    localparam logic [52:0] TBL [NROW] = '{
        {24'h000000, 24'h400468, 1'b0, 3'b000, 1'b1},
        {24'h000000, 24'h4004E8, 1'b0, 3'b000, 1'b0},
        {24'h000000, 24'h400405, 1'b1, 3'b000, 1'b1},
        {24'h000000, 24'h400405, 1'b0, 3'b000, 1'b0},
        {24'h000000, 24'h400460, 1'b0, 3'b100, 1'b1},
        {24'h000000, 24'h4004E4, 1'b0, 3'b000, 1'b1},
        {24'h000000, 24'h400465, 1'b0, 3'b001, 1'b1},
        {24'h700080, 24'h400400, 1'b0, 3'b000, 1'b1},
        {24'h700068, 24'h4004E8, 1'b0, 3'b000, 1'b0},
        {24'h7000E0, 24'h400460, 1'b0, 3'b000, 1'b0},
        {24'h7000A5, 24'h4004A5, 1'b0, 3'b000, 1'b0},
        {24'h3ABCDE, 24'h400468, 1'b0, 3'b000, 1'b1},
        {24'h000000, 24'h4004E0, 1'b0, 3'b100, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        up_index_clr = 0; up_data_we = 0; up_data = '0; start = 0;
        host_usave_set = 0; host_uload_set = 0;
        stat_busy = 0; stat_asave = 0; stat_aload = 0; xfer_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic up_clr();
        up_index_clr = 1; @(negedge clk); up_index_clr = 0;
    endtask

    task automatic up_word(input logic [23:0] w);
        up_data_we = 1; up_data = w; @(negedge clk); up_data_we = 0;
    endtask

    task automatic host_save_pulse();
        host_usave_set = 1; @(negedge clk); host_usave_set = 0;
    endtask

    task automatic snap();
        b_swap = c_swap; b_cur = c_cur; b_ptr = c_ptr; b_req = c_req;
    endtask

    task automatic kick();
        start = 1; @(negedge clk); start = 0;
    endtask

    task automatic wait_idle(input string tag, input int lim);
        int k = 0;
        while (busy && k < lim) begin
            @(negedge clk);
            k++;
        end
        chk(tag, {31'd0, busy}, 32'd0);
    endtask

    task automatic serve(input string tag, input logic [13:0] ea, input logic [19:0] ec,
                         input logic [19:0] ep, input logic ed, input logic eb);
        int k = 0;
        while (!xfer_req && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk({tag, " req"}, {31'd0, xfer_req}, 32'd1);
        chk({tag, " addr"}, {18'd0, xfer_addr}, {18'd0, ea});
        chk({tag, " cnt"}, {12'd0, xfer_cnt}, {12'd0, ec});
        chk({tag, " pos"}, {12'd0, xfer_pos}, {12'd0, ep});
        chk({tag, " dir"}, {31'd0, xfer_dir}, {31'd0, ed});
        chk({tag, " bulk"}, {31'd0, xfer_bulk}, {31'd0, eb});
        repeat (3) @(negedge clk);
        chk({tag, " held"}, {31'd0, xfer_req}, 32'd1);
        chk({tag, " addr held"}, {18'd0, xfer_addr}, {18'd0, ea});
        xfer_done = 1; @(negedge clk); xfer_done = 0;
        chk({tag, " dropped"}, {31'd0, xfer_req}, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R2: reset state
        chk("R2 reset busy", {31'd0, busy}, 32'd0);
        chk("R2 reset req", {31'd0, xfer_req}, 32'd0);
        chk("R12 reset pulses", {29'd0, pulse_to_swap, pulse_to_cur, pulse_ctx_ptr}, 32'd0);

        // R7 R9 R10 R13: branch table
        for (int i = 0; i < NROW; i++) begin
            do_reset();
            {stat_busy, stat_asave, stat_aload} = TBL[i][3:1];
            if (TBL[i][4]) host_save_pulse();
            up_clr();
            up_word(TBL[i][52:29]);
            up_word(TBL[i][28:5]);
            up_word(24'h600007);
            up_word(24'h60000E);
            up_word(24'h600009);
            up_word(24'h60000E);
            snap();
            kick();
            wait_idle("R7 table end", 40);
            chk($sformatf("R7 R10 row %0d taken", i), c_cur - b_cur, {31'd0, TBL[i][0]});
            chk($sformatf("R7 R9 row %0d fallthrough", i), c_swap - b_swap, {31'd0, ~TBL[i][0]});
        end

        // R2 R3: end command at address 0, busy timing
        do_reset();
        up_clr(); up_word(24'h60000E);
        start = 1; @(negedge clk); start = 0;
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R3 busy after end", {31'd0, busy}, 32'd0);

        // R3: running past the last word
        do_reset();
        up_clr(); up_word(24'h600009);
        snap();
        start = 1; @(negedge clk); start = 0;
        @(negedge clk);
        chk("R3 busy at last word", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R3 busy past end", {31'd0, busy}, 32'd0);
        chk("R3 pulse before end", c_cur - b_cur, 32'd1);

        // R3: words after end are not run
        do_reset();
        up_clr(); up_word(24'h600009); up_word(24'h60000E); up_word(24'h600007);
        snap(); kick(); wait_idle("R3 end stop", 40);
        chk("R3 no word after end", c_swap - b_swap, 32'd0);

        // R4 R5 R6: transfers
        do_reset();
        up_clr();
        up_word(24'h700080);
        up_word(24'h10C123);
        up_word(24'h700000);
        up_word(24'h116ABC);
        up_word(24'h200345);
        up_word(24'h800041);
        up_word(24'h60000E);
        kick();
        serve("R4 save xfer", 14'h0123, 20'd3, 20'd0, 1'b1, 1'b0);
        serve("R5 load xfer", 14'h2ABC, 20'd5, 20'd3, 1'b0, 1'b0);
        serve("R6 bulk xfer", 14'h0041, 20'h00345, 20'd8, 1'b0, 1'b1);
        wait_idle("R4 xfer end", 40);

        // R8: wait on a host flag, then wait on a clear flag
        do_reset();
        up_clr(); up_word(24'h500085); up_word(24'h600009); up_word(24'h60000E);
        snap(); kick();
        repeat (10) @(negedge clk);
        chk("R8 stalled busy", {31'd0, busy}, 32'd1);
        chk("R8 stalled no pulse", c_cur - b_cur, 32'd0);
        host_save_pulse();
        wait_idle("R8 released", 40);
        chk("R8 released pulse", c_cur - b_cur, 32'd1);
        do_reset();
        up_clr(); up_word(24'h500025); up_word(24'h600009); up_word(24'h60000E);
        snap(); kick(); wait_idle("R8 clear wait", 40);
        chk("R8 clear wait passes", c_cur - b_cur, 32'd1);

        // R11: host set and program clear on the same edge
        do_reset();
        up_clr();
        up_word(24'h700005); up_word(24'h400405); up_word(24'h600007);
        up_word(24'h60000E); up_word(24'h600009); up_word(24'h60000E);
        snap();
        start = 1; @(negedge clk); start = 0;
        host_usave_set = 1; @(negedge clk); host_usave_set = 0;
        wait_idle("R11 end", 40);
        chk("R11 host wins", c_cur - b_cur, 32'd1);
        chk("R11 host wins path", c_swap - b_swap, 32'd0);
        // control: program clear alone takes effect
        do_reset();
        host_save_pulse();
        up_clr();
        up_word(24'h700005); up_word(24'h400405); up_word(24'h600007);
        up_word(24'h60000E); up_word(24'h600009); up_word(24'h60000E);
        snap(); kick(); wait_idle("R9 clear end", 40);
        chk("R9 program clear", c_swap - b_swap, 32'd1);

        // R12: notification pulses
        do_reset();
        up_clr();
        up_word(24'h600007); up_word(24'h60000A); up_word(24'h600009);
        up_word(24'h60000A); up_word(24'h60000E);
        snap(); kick(); wait_idle("R12 end", 40);
        chk("R12 swap pulses", c_swap - b_swap, 32'd1);
        chk("R12 cur pulses", c_cur - b_cur, 32'd1);
        chk("R12 ptr pulses", c_ptr - b_ptr, 32'd2);

        // R13: unknown words are skipped
        do_reset();
        up_clr();
        up_word(24'h300000); up_word(24'h9FFFFF); up_word(24'hF12345);
        up_word(24'h60000F); up_word(24'h600009); up_word(24'h60000E);
        snap(); kick(); wait_idle("R13 end", 40);
        chk("R13 reached marker", c_cur - b_cur, 32'd1);
        chk("R13 no request", c_req - b_req, 32'd0);

        // R1: the 257th word is dropped
        do_reset();
        up_clr();
        up_word(24'h600009);
        for (int j = 1; j < 256; j++) up_word(24'h000000);
        up_word(24'h600007);
        snap(); kick(); wait_idle("R1 full run", 600);
        chk("R1 word 0 kept", c_cur - b_cur, 32'd1);
        chk("R1 overflow dropped", c_swap - b_swap, 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule